// File: doc/BRIEF.md
# Flagged Integer ALU

A combinational integer arithmetic-logic unit for a simple processor datapath. It takes two 32-bit operands, `a_i` and `b_i`, and a 5-bit function code. It returns a 32-bit result and four condition flags. The function code steers the operation to one of three units:

- an adder/subtractor;
- a barrel shifter that shifts left or right;
- a bitwise logic unit.

A final multiplexer passes the chosen unit's output to `res_o`.

The flags are packed as `{Z, V, C, N}`, with Z in bit 3 and N in bit 0. A controller can test these flags after a subtraction to evaluate any signed or unsigned comparison. The block has no clock and no state.

Top module: `flag_alu`

## Requirements
- R1: The function code `fn_i` has five fields.
  - Bit 4 is `sub`, bits 3:2 are `bsel`, bit 1 is `shft` and bit 0 is `math`.
  - The unit is chosen in this order: `shft`=1 selects the shifter, whatever `math` is.
  - Otherwise `math`=1 selects the adder.
  - Otherwise the logic unit is selected.
- R2: When the adder is selected with `sub`=0, `res_o` is A+B modulo 2^32.
- R3: When the adder is selected with `sub`=1, `res_o` is A-B modulo 2^32.
  - The subtraction is formed as A + ~B + 1, so C=1 exactly when A >= B unsigned.
- R4: When the shifter is selected, B is shifted by the amount in A[4:0]; A[31:5] has no effect.
  - `bsel`=10 is a logical right shift.
  - `bsel`=11 is an arithmetic right shift.
  - `bsel`=00 and `bsel`=01 are a left shift that fills with zeros.
- R5: When the logic unit is selected, `bsel` picks the operation: 00 AND, 01 OR, 10 XOR, 11 NOR.
- R6: Z (`flags_o[3]`) is 1 exactly when `res_o` is zero.
- R7: N (`flags_o[0]`) equals `res_o[31]`.
- R8: In adder mode, C (`flags_o[1]`) is the carry out of bit 31. For example, 1 + 0xFFFFFFFF sets C.
- R9: In adder mode, V (`flags_o[2]`) is 1 exactly when the exact signed sum or difference lies outside [-2^31, 2^31-1].
- R10: In shifter or logic mode, V and C are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 32 | Operand A; bits 4:0 give the shift amount |
| b_i | input | 32 | Operand B; the value that is shifted |
| fn_i | input | 5 | Function code {sub, bsel[1:0], shft, math} |
| res_o | output | 32 | Result |
| flags_o | output | 4 | Flags {Z, V, C, N} |

## Verification
The operand pairs for the adder are chosen to sit at the edges of the flags:
- 1 + 0xFFFFFFFF wraps to zero with a carry;
- 0x7FFFFFFF + 1 and 0x80000000 - 1 overflow in sign;
- 0 - 0 produces a carry because there is no borrow.

These pairs separate a correct carry chain and overflow rule from a wrong carry-in or a wrong sign test. Random operands drive every operation, which exposes a swapped field or a wrong operation select.

The shifter is driven with several amounts:
- 0, 31 and 32, and an A whose upper bits are set, to confirm that only A[4:0] counts;
- a negative B under both right shifts, to show the difference between zero fill and sign fill.

Codes with both `shft` and `math` set, and `bsel`=01 in shift mode, confirm the select order.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef struct packed {
    logic       sub;
    logic [1:0] bsel;
    logic       shft;
    logic       math;
  } alu_fn_t;

  typedef enum logic [1:0] {
    LOG_AND = 2'b00,
    LOG_OR  = 2'b01,
    LOG_XOR = 2'b10,
    LOG_NOR = 2'b11
  } log_op_e;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o,
  output logic         c_o,
  output logic         v_o
);
  logic [W-1:0] bx;
  logic [W:0]   t;

  // B is inverted for subtraction and sub feeds the carry-in
  assign bx = b_i ^ {W{sub_i}};
  assign t  = {1'b0, a_i} + {1'b0, bx} + {{W{1'b0}}, sub_i};
  assign sum_o = t[W-1:0];
  assign c_o   = t[W];
  assign v_o   = (a_i[W-1] == bx[W-1]) && (t[W-1] != a_i[W-1]);
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter #(
  parameter int W   = 32,
  parameter int SHW = $clog2(W)
) (
  input  logic [W-1:0]   b_i,
  input  logic [SHW-1:0] amt_i,
  input  logic [1:0]     bsel_i,
  output logic [W-1:0]   res_o
);
  logic left, fill;
  logic [W-1:0] b_rev, st_rev;
  logic [W-1:0] stg [0:SHW];

  assign left = ~bsel_i[1];
  assign fill = bsel_i[1] & bsel_i[0] & b_i[W-1];

  // a left shift is a right shift on bit-reversed data
  for (genvar i = 0; i < W; i++) begin : g_rev
    assign b_rev[i]  = b_i[W-1-i];
    assign st_rev[i] = stg[SHW][W-1-i];
  end

  assign stg[0] = left ? b_rev : b_i;

  for (genvar k = 0; k < SHW; k++) begin : g_stage
    localparam int S = 1 << k;
    assign stg[k+1] = amt_i[k] ? {{S{fill}}, stg[k][W-1:S]} : stg[k];
  end

  assign res_o = left ? st_rev : stg[SHW];
endmodule

// File: rtl/alu_logic.sv
module alu_logic
  import alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [1:0]   bsel_i,
  output logic [W-1:0] res_o
);
  always_comb begin
    unique case (log_op_e'(bsel_i))
      LOG_AND: res_o = a_i & b_i;
      LOG_OR:  res_o = a_i | b_i;
      LOG_XOR: res_o = a_i ^ b_i;
      default: res_o = ~(a_i | b_i);
    endcase
  end
endmodule

// File: rtl/flag_alu.sv
module flag_alu
  import alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [4:0]   fn_i,
  output logic [W-1:0] res_o,
  output logic [3:0]   flags_o
);
  localparam int SHW = $clog2(W);

  alu_fn_t      fn;
  logic [W-1:0] add_res, sh_res, log_res;
  logic         add_c, add_v, v_f, c_f;

  assign fn = alu_fn_t'(fn_i);

  alu_addsub #(.W(W)) u_add (
    .a_i(a_i), .b_i(b_i), .sub_i(fn.sub),
    .sum_o(add_res), .c_o(add_c), .v_o(add_v)
  );

  alu_shifter #(.W(W), .SHW(SHW)) u_sh (
    .b_i(b_i), .amt_i(a_i[SHW-1:0]), .bsel_i(fn.bsel), .res_o(sh_res)
  );

  alu_logic #(.W(W)) u_log (
    .a_i(a_i), .b_i(b_i), .bsel_i(fn.bsel), .res_o(log_res)
  );

  always_comb begin
    if (fn.shft) begin
      res_o = sh_res;
      v_f = 1'b0;
      c_f = 1'b0;
    end else if (fn.math) begin
      res_o = add_res;
      v_f = add_v;
      c_f = add_c;
    end else begin
      res_o = log_res;
      v_f = 1'b0;
      c_f = 1'b0;
    end
  end

  assign flags_o = {~|res_o, v_f, c_f, res_o[W-1]};
endmodule

// File: rtl/flag_alu_chk.sv
module flag_alu_chk #(
  parameter int W = 32
) (
  input logic [W-1:0] a_i,
  input logic [W-1:0] b_i,
  input logic [4:0]   fn_i,
  input logic [W-1:0] res_o,
  input logic [3:0]   flags_o
);
  always_comb begin
    if (!$isunknown({a_i, b_i, fn_i, res_o, flags_o})) begin
      p_zero_r6: assert (flags_o[3] == (res_o == '0));
      p_neg_r7: assert (flags_o[0] == res_o[W-1]);
      if (fn_i[1] || !fn_i[0]) begin
        p_no_vc_r10: assert (flags_o[2:1] == 2'b00);
      end
      if (!fn_i[1] && fn_i[0] && !fn_i[4]) begin
        p_add_r2: assert (res_o == a_i + b_i);
      end
      if (!fn_i[1] && fn_i[0] && fn_i[4]) begin
        p_sub_r3: assert (res_o == a_i - b_i);
        p_sub_carry_r3: assert (flags_o[1] == (a_i >= b_i));
      end
      if (!fn_i[1] && !fn_i[0] && fn_i[3:2] == 2'b10) begin
        p_xor_r5: assert (res_o == (a_i ^ b_i));
      end
    end
  end
endmodule

bind flag_alu flag_alu_chk #(.W(W)) u_chk (.*);

// File: tb/flag_alu_test.sv
`timescale 1ns/1ps
module flag_alu_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] a, b, res;
  logic [4:0]  fn;
  logic [3:0]  flags;
  int n_chk = 0, n_bad = 0;

  localparam logic [4:0] F_ADD = 5'b00001, F_SUB = 5'b10001,
    F_SLL = 5'b00010, F_SLL1 = 5'b00110, F_SRL = 5'b01010, F_SRA = 5'b01110,
    F_SHM = 5'b01011, F_AND = 5'b00000, F_OR = 5'b00100, F_XOR = 5'b01000,
    F_NOR = 5'b01100;

  always #2 clk = ~clk;

  flag_alu uut (.a_i(a), .b_i(b), .fn_i(fn), .res_o(res), .flags_o(flags));

  task automatic model(input logic [31:0] x, input logic [31:0] y, input logic [4:0] f,
                       output logic [31:0] r, output logic [3:0] fl);
    logic [32:0] t;
    longint sx, sy, s;
    int amt;
    logic v, c;
    v = 0; c = 0;
    amt = int'(x % 32);
    if (f[1]) begin
      if (f[3:2] == 2'b10) r = y >> amt;
      else if (f[3:2] == 2'b11) r = $unsigned($signed(y) >>> amt);
      else r = y << amt;
    end else if (f[0]) begin
      sx = longint'($signed(x)); sy = longint'($signed(y));
      if (f[4]) begin t = {1'b0, x} + {1'b0, ~y} + 33'd1; s = sx - sy; end
      else begin t = {1'b0, x} + {1'b0, y}; s = sx + sy; end
      r = t[31:0]; c = t[32];
      v = (s > 64'sd2147483647) || (s < -64'sd2147483648);
    end else begin
      case (f[3:2])
        2'b00: r = x & y;
        2'b01: r = x | y;
        2'b10: r = x ^ y;
        default: r = ~(x | y);
      endcase
    end
    fl = {r == 32'd0, v, c, r[31]};
  endtask

  task automatic run(input string tag, input logic [31:0] x, input logic [31:0] y,
                     input logic [4:0] f);
    logic [31:0] er;
    logic [3:0] ef;
    @(negedge clk);
    a = x; b = y; fn = f;
    model(x, y, f, er, ef);
    @(posedge clk);
    n_chk++;
    if (res !== er || flags !== ef) begin
      n_bad++;
      $display("FAIL %s a=%h b=%h fn=%b: res=%h flags=%b expected res=%h flags=%b",
               tag, x, y, f, res, flags, er, ef);
    end
  endtask

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    a = '0; b = '0; fn = F_AND;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    run("R6 idle zero", 32'd0, 32'd0, F_AND);
    // adder edges
    run("R8 carry 1+(-1)", 32'd1, 32'hFFFF_FFFF, F_ADD);
    run("R9 add overflow", 32'h7FFF_FFFF, 32'd1, F_ADD);
    run("R9 neg overflow", 32'h8000_0000, 32'h8000_0000, F_ADD);
    run("R3 sub overflow", 32'h8000_0000, 32'd1, F_SUB);
    run("R3 sub 0-0 carry", 32'd0, 32'd0, F_SUB);
    run("R3 sub borrow", 32'd3, 32'd5, F_SUB);
    run("R2 add plain", 32'd100, 32'd23, F_ADD);
    // shifter edges
    run("R4 sll 31", 32'd31, 32'd1, F_SLL);
    run("R4 amt 32 is 0", 32'd32, 32'hDEAD_BEEF, F_SRL);
    run("R4 upper A ignored", 32'hFFFF_FFE1, 32'h8000_0000, F_SRA);
    run("R4 sra neg", 32'd4, 32'hF000_0000, F_SRA);
    run("R4 srl neg", 32'd4, 32'hF000_0000, F_SRL);
    run("R4 bsel01 left", 32'd3, 32'h0000_0011, F_SLL1);
    run("R1 shft over math", 32'd8, 32'h8000_0000, F_SHM);
    run("R10 logic no flags", 32'hFFFF_FFFF, 32'hFFFF_FFFF, F_AND);
    run("R5 nor", 32'h0F0F_0000, 32'h00F0_0000, F_NOR);
    run("R7 or neg", 32'h8000_0000, 32'd1, F_OR);
    for (int i = 0; i < 300; i++) begin
      logic [31:0] x, y;
      x = $urandom; y = $urandom;
      run("R2 rnd", x, y, F_ADD);
      run("R3 rnd", x, y, F_SUB);
      run("R4 rnd sll", x, y, F_SLL);
      run("R4 rnd srl", x, y, F_SRL);
      run("R4 rnd sra", x, y, F_SRA);
      run("R5 rnd and", x, y, F_AND);
      run("R5 rnd or", x, y, F_OR);
      run("R5 rnd xor", x, y, F_XOR);
      run("R5 rnd nor", x, y, F_NOR);
      run("R1 rnd shm", x, y, F_SHM);
    end
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule